// File: doc/BRIEF.md
# Processor trap entry sequencer

This block performs the architectural state update that a windowed 64-bit RISC core makes when it takes a trap. The core's trap logic raises a one-cycle request with a 9-bit trap type while presenting its current trap level, processor state word, condition codes, address space identifier, window pointer, save-window count, PC, next PC and trap base address. One clock later the block returns the updated registers, writes one entry of the trap stack, and gives the new PC and next PC at the trap vector. A single-cycle completion pulse goes with these updates.

The trap type sets three things. It decides which global register set becomes active. It decides whether the window pointer moves, which happens for spill, fill and clean-window traps. It also becomes the offset into the trap table. The trap level decides whether the trap is taken normally or in the reduced-state mode. When the core is already at its deepest nesting level, the trap is refused and the block enters a sticky error state. The number of register windows (NWIN) and the maximum trap level (MAXTL) are parameters.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `done`, `halt` and `ts_we` are 0 and every registered output is 0.
- R2: A request taken while `halt` is 0 and `cur_tl` < MAXTL sets `done` and `ts_we` to 1 for exactly the next cycle. Both return to 0 in the cycle after that unless another request follows.
- R3: When `cur_tl` < MAXTL-1, `nxt_tl` = `cur_tl`+1 and the RED bit (bit 5) of `nxt_pstate` is copied unchanged from `cur_pstate`.
- R4: When `cur_tl` = MAXTL-1, `nxt_tl` = MAXTL and bit 5 (RED) of `nxt_pstate` is set.
- R5: A request with `cur_tl` >= MAXTL gives no `done` and leaves every output unchanged, and `halt` goes to 1 and stays 1 until reset. While `halt` is 1, further requests are ignored.
- R6: `ts_tstate` (40 bits) carries `cur_ccr` in bits 39:32, `cur_asi` in 31:24, `cur_pstate` AND 0xF3F in 19:8, and the pre-trap `cur_cwp` zero-extended in 7:0. All other bits are 0.
- R7: `ts_idx` equals the new trap level, `ts_tpc` equals `cur_pc` and `ts_tnpc` equals `cur_npc`.
- R8: `nxt_pstate` sets PEF (bit 4) and PRIV (bit 2) and clears AG (bit 0), MG (bit 10) and IG (bit 11), then sets one of those three. IG is set for type 0x060. MG is set for types 0x064 to 0x06F. AG is set for every other type. All other bits keep their values.
- R9: Type 0x024 (clean window) gives `nxt_cwp` = (`cur_cwp`-1) mod NWIN.
- R10: Types 0x080 to 0x0BF (spill) give `nxt_cwp` = (`cur_cwp`-`cur_cansave`-2) mod NWIN.
- R11: Types 0x0C0 to 0x0FF (fill) give `nxt_cwp` = (`cur_cwp`+1) mod NWIN. Every other type leaves `nxt_cwp` = `cur_cwp`.
- R12: `nxt_tba` keeps `cur_tba` bits 63:15. Bit 14 is set when the new trap level is greater than 1, bits 13:5 hold the trap type, and bits 4:0 are 0.
- R13: `nxt_pc` equals `nxt_tba` and `nxt_npc` equals `nxt_tba`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_type | input | 9 | Trap type of the request |
| cur_tl | input | TLW | Current trap level |
| cur_pstate | input | 12 | Current processor state word |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_cwp | input | CW | Current window pointer |
| cur_cansave | input | CW | Current save-window count |
| cur_pc | input | VA_W | Current PC |
| cur_npc | input | VA_W | Current next PC |
| cur_tba | input | VA_W | Current trap base address |
| done | output | 1 | Update pulse |
| halt | output | 1 | Sticky error state |
| nxt_tl | output | TLW | Updated trap level |
| nxt_pstate | output | 12 | Updated processor state word |
| nxt_cwp | output | CW | Updated window pointer |
| nxt_tba | output | VA_W | Updated trap base with vector offset |
| nxt_pc | output | VA_W | New PC |
| nxt_npc | output | VA_W | New next PC |
| ts_we | output | 1 | Trap stack write strobe |
| ts_idx | output | TLW | Trap stack entry index |
| ts_tstate | output | 40 | Packed saved state |
| ts_tpc | output | VA_W | Saved PC |
| ts_tnpc | output | VA_W | Saved next PC |

## Verification
The bench targets the window pointer wrap in both directions, all at NWIN=8:
- A clean trap at window 0 must land on window 7.
- A fill at window 7 must land on window 0.
- A spill with a large save count must go below zero and wrap.

A design that drops the modulo step would return out-of-range pointers in these cases. The bench also goes after the trap level boundaries:
- At MAXTL-1 the trap is still taken but RED must be set.
- At MAXTL the trap must be refused, and requests after that must stay ignored. A wrong comparison would either take the refused trap or never set RED.

Two further corner cases are covered:
- The MMU groups are checked at their first and last types and just outside them. An off-by-one in the group decode would pick the wrong global set.
- Traps at level 0 and level 1 are both run. If bit 14 of the vector were based on the old level instead of the new one, the vector would be off by one table half.

// File: rtl/trap_seq_pkg.sv
// Package: shared constants and types for the trap entry sequencer.
// Assumes a 12-bit processor state word and a 9-bit trap type.
package trap_seq_pkg;
    localparam int PS_W    = 12;
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;
    localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

    localparam int TT_W = 9;
    localparam logic [TT_W-1:0] TT_CLEANWIN = 9'h024;
    localparam logic [TT_W-1:0] TT_INTVEC   = 9'h060;
    localparam logic [TT_W-1:0] TT_IMMU     = 9'h064;
    localparam logic [TT_W-1:0] TT_DMMU     = 9'h068;
    localparam logic [TT_W-1:0] TT_DPROTECT = 9'h06C;

    localparam int TSTATE_W = 40;

    typedef enum logic [1:0] {
        WFIX_NONE  = 2'd0,
        WFIX_CLEAN = 2'd1,
        WFIX_SPILL = 2'd2,
        WFIX_FILL  = 2'd3
    } wfix_e;

    typedef enum logic [1:0] {
        GSEL_ALT = 2'd0,
        GSEL_MMU = 2'd1,
        GSEL_INT = 2'd2
    } gsel_e;
endpackage

// File: rtl/trap_classify.sv
// Module: trap_classify
// Decodes a trap type into a window-pointer fixup kind and a global set choice.
// Purely combinational; assumes trap types above 0x17F do not arrive.
module trap_classify
    import trap_seq_pkg::*;
(
    input  logic [TT_W-1:0] tt,
    output wfix_e           wfix,
    output gsel_e           gsel
);
    // Window fixup: clean window by exact type, spill/fill by bits 8:6.
    always_comb begin
        if (tt == TT_CLEANWIN)       wfix = WFIX_CLEAN;
        else if (tt[8:6] == 3'b010)  wfix = WFIX_SPILL;
        else if (tt[8:6] == 3'b011)  wfix = WFIX_FILL;
        else                         wfix = WFIX_NONE;
    end

    // Global set choice: interrupt vector, three MMU groups of four, or alternate.
    always_comb begin
        if (tt == TT_INTVEC)
            gsel = GSEL_INT;
        else if ((tt[8:2] == TT_IMMU[8:2]) || (tt[8:2] == TT_DMMU[8:2]) ||
                 (tt[8:2] == TT_DPROTECT[8:2]))
            gsel = GSEL_MMU;
        else
            gsel = GSEL_ALT;
    end
endmodule

// File: rtl/trap_cwp_fix.sv
// Module: trap_cwp_fix
// Computes the post-trap window pointer modulo NWIN.
// Assumes cwp and cansave are already below NWIN.
module trap_cwp_fix
    import trap_seq_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  wfix_e         wfix,
    input  logic [CW-1:0] cwp,
    input  logic [CW-1:0] cansave,
    output logic [CW-1:0] cwp_out
);
    int biased;

    // Offset kept non-negative by adding multiples of NWIN before the modulo.
    always_comb begin
        unique case (wfix)
            WFIX_CLEAN: biased = int'(cwp) + NWIN - 1;
            WFIX_SPILL: biased = int'(cwp) + 2 * NWIN - int'(cansave) - 2;
            WFIX_FILL:  biased = int'(cwp) + 1;
            default:    biased = int'(cwp);
        endcase
        cwp_out = CW'(biased % NWIN);
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Module: trap_entry_seq (top)
// Takes a trap request and, one cycle later, presents the updated trap level,
// state word, window pointer, vector and the trap stack entry to be written.
// Assumes cur_tl <= MAXTL and cur_cwp/cur_cansave below NWIN.
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int MAXTL = 5,
    parameter int VA_W  = 64,
    localparam int CW   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int TLW  = $clog2(MAXTL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic [TT_W-1:0]     trap_type,
    input  logic [TLW-1:0]      cur_tl,
    input  logic [PS_W-1:0]     cur_pstate,
    input  logic [7:0]          cur_ccr,
    input  logic [7:0]          cur_asi,
    input  logic [CW-1:0]       cur_cwp,
    input  logic [CW-1:0]       cur_cansave,
    input  logic [VA_W-1:0]     cur_pc,
    input  logic [VA_W-1:0]     cur_npc,
    input  logic [VA_W-1:0]     cur_tba,
    output logic                done,
    output logic                halt,
    output logic [TLW-1:0]      nxt_tl,
    output logic [PS_W-1:0]     nxt_pstate,
    output logic [CW-1:0]       nxt_cwp,
    output logic [VA_W-1:0]     nxt_tba,
    output logic [VA_W-1:0]     nxt_pc,
    output logic [VA_W-1:0]     nxt_npc,
    output logic                ts_we,
    output logic [TLW-1:0]      ts_idx,
    output logic [TSTATE_W-1:0] ts_tstate,
    output logic [VA_W-1:0]     ts_tpc,
    output logic [VA_W-1:0]     ts_tnpc
);
    localparam logic [TLW-1:0] TL_MAX  = TLW'(MAXTL);
    localparam logic [TLW-1:0] TL_LAST = TLW'(MAXTL - 1);

    wfix_e               wfix;
    gsel_e               gsel;
    logic [CW-1:0]       cwp_fixed;
    logic                tl_full;
    logic                red_entry;
    logic [TLW-1:0]      tl_inc;
    logic [PS_W-1:0]     ps_new;
    logic [TSTATE_W-1:0] tstate_pack;
    logic [VA_W-1:0]     vector;

    trap_classify u_class (
        .tt   (trap_type),
        .wfix (wfix),
        .gsel (gsel)
    );

    trap_cwp_fix #(.NWIN(NWIN), .CW(CW)) u_cwp (
        .wfix    (wfix),
        .cwp     (cur_cwp),
        .cansave (cur_cansave),
        .cwp_out (cwp_fixed)
    );

    // Trap level decision: refuse at MAXTL, reduced state at MAXTL-1.
    always_comb begin
        tl_full   = (cur_tl >= TL_MAX);
        red_entry = (cur_tl == TL_LAST);
        tl_inc    = cur_tl + TLW'(1);
    end

    // New state word: privilege and FP enable, one global set, optional RED.
    always_comb begin
        ps_new = cur_pstate;
        ps_new[PS_AG]   = (gsel == GSEL_ALT);
        ps_new[PS_MG]   = (gsel == GSEL_MMU);
        ps_new[PS_IG]   = (gsel == GSEL_INT);
        ps_new[PS_PEF]  = 1'b1;
        ps_new[PS_PRIV] = 1'b1;
        if (red_entry) ps_new[PS_RED] = 1'b1;
    end

    // Saved state word packing from the pre-trap registers.
    always_comb begin
        tstate_pack          = '0;
        tstate_pack[39:32]   = cur_ccr;
        tstate_pack[31:24]   = cur_asi;
        tstate_pack[19:8]    = cur_pstate & PS_SAVE_MASK;
        tstate_pack[CW-1:0]  = cur_cwp;
    end

    // Vector: base upper bits, nesting flag, trap type, 32-byte slot.
    always_comb begin
        vector        = cur_tba;
        vector[14]    = (tl_inc > TLW'(1));
        vector[13:5]  = trap_type;
        vector[4:0]   = 5'd0;
    end

    // Output register stage; error state is sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            halt       <= 1'b0;
            nxt_tl     <= '0;
            nxt_pstate <= '0;
            nxt_cwp    <= '0;
            nxt_tba    <= '0;
            nxt_pc     <= '0;
            nxt_npc    <= '0;
            ts_we      <= 1'b0;
            ts_idx     <= '0;
            ts_tstate  <= '0;
            ts_tpc     <= '0;
            ts_tnpc    <= '0;
        end else begin
            done  <= 1'b0;
            ts_we <= 1'b0;
            if (trap_req && !halt) begin
                if (tl_full) begin
                    halt <= 1'b1;
                end else begin
                    done       <= 1'b1;
                    ts_we      <= 1'b1;
                    nxt_tl     <= tl_inc;
                    nxt_pstate <= ps_new;
                    nxt_cwp    <= cwp_fixed;
                    nxt_tba    <= vector;
                    nxt_pc     <= vector;
                    nxt_npc    <= vector + VA_W'(4);
                    ts_idx     <= tl_inc;
                    ts_tstate  <= tstate_pack;
                    ts_tpc     <= cur_pc;
                    ts_tnpc    <= cur_npc;
                end
            end
        end
    end

    // R2
    done_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(trap_req));
    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
    // R5
    no_done_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt) |-> !done);
    // R3
    tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nxt_tl == $past(cur_tl) + TLW'(1)));
    // R8
    priv_pef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nxt_pstate[PS_PRIV] && nxt_pstate[PS_PEF]));
    // R8
    one_gset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({nxt_pstate[PS_AG], nxt_pstate[PS_MG], nxt_pstate[PS_IG]}) == 1));
    // R13
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nxt_npc == nxt_pc + VA_W'(4)));
    // R11
    cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(nxt_cwp) < NWIN));
endmodule

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int NWIN  = 8;
    localparam int MAXTL = 5;
    localparam int VA_W  = 64;
    localparam int CW    = $clog2(NWIN);
    localparam int TLW   = $clog2(MAXTL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [8:0]      trap_type = '0;
    logic [TLW-1:0]  cur_tl = '0;
    logic [11:0]     cur_pstate = '0;
    logic [7:0]      cur_ccr = '0;
    logic [7:0]      cur_asi = '0;
    logic [CW-1:0]   cur_cwp = '0;
    logic [CW-1:0]   cur_cansave = '0;
    logic [VA_W-1:0] cur_pc = '0;
    logic [VA_W-1:0] cur_npc = '0;
    logic [VA_W-1:0] cur_tba = '0;
    logic            done, halt, ts_we;
    logic [TLW-1:0]  nxt_tl, ts_idx;
    logic [11:0]     nxt_pstate;
    logic [CW-1:0]   nxt_cwp;
    logic [VA_W-1:0] nxt_tba, nxt_pc, nxt_npc, ts_tpc, ts_tnpc;
    logic [39:0]     ts_tstate;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    trap_entry_seq #(.NWIN(NWIN), .MAXTL(MAXTL), .VA_W(VA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_tl(cur_tl), .cur_pstate(cur_pstate), .cur_ccr(cur_ccr),
        .cur_asi(cur_asi), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_tba(cur_tba),
        .done(done), .halt(halt), .nxt_tl(nxt_tl), .nxt_pstate(nxt_pstate),
        .nxt_cwp(nxt_cwp), .nxt_tba(nxt_tba), .nxt_pc(nxt_pc), .nxt_npc(nxt_npc),
        .ts_we(ts_we), .ts_idx(ts_idx), .ts_tstate(ts_tstate),
        .ts_tpc(ts_tpc), .ts_tnpc(ts_tnpc)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int ref_cwp(input logic [8:0] tt, input int cwp, input int cans);
        if (tt == 9'h024)           return (cwp + NWIN - 1) % NWIN;
        else if (tt[8:6] == 3'b010) return (cwp + 2 * NWIN - cans - 2) % NWIN;
        else if (tt[8:6] == 3'b011) return (cwp + 1) % NWIN;
        return cwp;
    endfunction

    function automatic logic [11:0] ref_ps(input logic [8:0] tt, input logic [11:0] ps, input int tl);
        logic [11:0] r = ps;
        r[0] = 1'b0; r[10] = 1'b0; r[11] = 1'b0;
        if (tt == 9'h060) r[11] = 1'b1;
        else if (tt >= 9'h064 && tt <= 9'h06F) r[10] = 1'b1;
        else r[0] = 1'b1;
        r[4] = 1'b1; r[2] = 1'b1;
        if (tl == MAXTL - 1) r[5] = 1'b1;
        return r;
    endfunction

    // Apply one trap and compare every updated field against the reference.
    task automatic do_trap(input logic [8:0] tt, input int tl, input logic [11:0] ps,
                           input int cwp, input int cans);
        logic [VA_W-1:0] vec;
        logic [39:0]     tsv;
        string           cw_req;
        @(negedge clk);
        trap_type   = tt;
        cur_tl      = TLW'(tl);
        cur_pstate  = ps;
        cur_cwp     = CW'(cwp);
        cur_cansave = CW'(cans);
        cur_ccr     = 8'($urandom);
        cur_asi     = 8'($urandom);
        cur_pc      = {$urandom, $urandom};
        cur_npc     = {$urandom, $urandom};
        cur_tba     = {$urandom, $urandom};
        trap_req    = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        vec = {cur_tba[VA_W-1:15], (tl + 1 > 1), tt, 5'd0};
        tsv = {cur_ccr, cur_asi, 4'd0, ps & 12'hF3F, 3'd0, 5'(cwp)};
        cw_req = (tt == 9'h024) ? "R9" : (tt[8:6] == 3'b010) ? "R10" : "R11";
        chk("R2 done", VA_W'(done), 1);
        chk("R2 ts_we", VA_W'(ts_we), 1);
        chk((tl == MAXTL - 1) ? "R4 tl" : "R3 tl", VA_W'(nxt_tl), VA_W'(tl + 1));
        chk((tl == MAXTL - 1) ? "R4 pstate" : "R8 pstate", VA_W'(nxt_pstate), VA_W'(ref_ps(tt, ps, tl)));
        chk(cw_req, VA_W'(nxt_cwp), VA_W'(ref_cwp(tt, cwp, cans)));
        chk("R6 tstate", VA_W'(ts_tstate), VA_W'(tsv));
        chk("R7 idx", VA_W'(ts_idx), VA_W'(tl + 1));
        chk("R7 tpc", ts_tpc, cur_pc);
        chk("R7 tnpc", ts_tnpc, cur_npc);
        chk("R12 tba", nxt_tba, vec);
        chk("R13 pc", nxt_pc, vec);
        chk("R13 npc", nxt_npc, vec + 4);
        @(negedge clk);
        chk("R2 done low", VA_W'(done), 0);
        chk("R2 ts_we low", VA_W'(ts_we), 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VA_W-1:0] held_pc;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", VA_W'(done), 0);
        chk("R1 halt", VA_W'(halt), 0);
        chk("R1 ts_we", VA_W'(ts_we), 0);
        chk("R1 pc", nxt_pc, 0);
        chk("R1 tl", VA_W'(nxt_tl), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners: window wraps (R9, R10, R11)
        do_trap(9'h024, 0, 12'h000, 0, 3);
        do_trap(9'h0C5, 1, 12'h0A8, 7, 0);
        do_trap(9'h084, 2, 12'hFFF, 1, 6);
        do_trap(9'h0BF, 0, 12'h123, 7, 7);
        // Global set boundaries (R8)
        do_trap(9'h060, 0, 12'hC01, 2, 2);
        do_trap(9'h063, 0, 12'h000, 2, 2);
        do_trap(9'h064, 1, 12'h801, 2, 2);
        do_trap(9'h06F, 1, 12'h000, 2, 2);
        do_trap(9'h070, 1, 12'h400, 2, 2);
        do_trap(9'h105, 3, 12'h000, 4, 1);
        // Trap level boundaries (R3, R4, R12)
        do_trap(9'h010, 0, 12'h000, 3, 3);
        do_trap(9'h010, 1, 12'h000, 3, 3);
        do_trap(9'h010, MAXTL - 1, 12'h000, 3, 3);
        // Constrained random
        for (int i = 0; i < 400; i++) begin
            do_trap(9'($urandom % 384), int'($urandom % MAXTL), 12'($urandom),
                    int'($urandom % NWIN), int'($urandom % NWIN));
        end
        // R5 refusal at MAXTL
        held_pc = nxt_pc;
        @(negedge clk);
        trap_type = 9'h011; cur_tl = TLW'(MAXTL); trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R5 halt set", VA_W'(halt), 1);
        chk("R5 no done", VA_W'(done), 0);
        chk("R5 pc held", nxt_pc, held_pc);
        @(negedge clk);
        trap_type = 9'h012; cur_tl = '0; trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R5 ignored done", VA_W'(done), 0);
        chk("R5 ignored pc", nxt_pc, held_pc);
        chk("R5 halt sticky", VA_W'(halt), 1);
        finish_run();
    end
endmodule